// File: doc/BRIEF.md
# BF16 Indexed Widening Multiply-Add Array

This block is the arithmetic stage for a vector multiply-add in which each 32-bit single-precision lane of a wide vector accumulates the product of two BFloat16 values. The first multiplicand of a lane is the low 16-bit half of that lane's own 32-bit slot in the first source vector. The second multiplicand is one BFloat16 element picked by a 3-bit index from the 128-bit segment of the second source vector that holds the lane. The same element is used by all four lanes of that segment.

Both multiplicands are widened to single precision by appending sixteen zero bits. The exact product is added to the lane's single-precision addend and rounded once. The result replaces the addend. Rounding mode, flush-to-zero and default-NaN controls apply to every lane. Invalid, overflow, underflow and inexact conditions are collected into sticky flags that only an explicit clear resets.

An operation begins with a one-cycle start pulse that captures every operand and control. The result vector and a one-cycle done pulse appear a fixed two clock edges later. Every lane is written on every operation.

Top module: `bf16_idx_fma`

## Requirements
- R1: After reset, `result` is all zeros, `done` is low and `flags` is zero.
- R2: Lane e (e = 0 to VLEN/32-1) takes its first multiplicand from bits [32e+15:32e] of `src_a`. Bits [32e+31:32e+16] have no effect on any result or flag.
- R3: Lane e takes its second multiplicand from 16-bit element 8*(e/4)+`idx` of `src_b` (element k occupies bits [16k+15:16k]). All four lanes of a 128-bit segment therefore use the same element.
- R4: Each lane returns addend + a*b, with a and b widened by appending 16 zero bits, computed exactly and rounded once. Every lane is written.
- R5: `rmode` selects 2'b00 nearest-even, 2'b01 toward +infinity, 2'b10 toward -infinity and 2'b11 toward zero. An exact halfway case in 2'b00 rounds to an even significand.
- R6: Infinity times zero gives 32'h7FC00000 and raises invalid, whatever the addend is, even a NaN.
- R7: A NaN input gives a quiet NaN. A signalling NaN raises invalid. The NaN that propagates is chosen in this order: signalling addend, signalling first, signalling second, then quiet addend, first, second. Its bit 22 is set. When `dnan` is 1, every NaN result is 32'h7FC00000.
- R8: An infinite product plus an infinite addend of opposite sign gives 32'h7FC00000 and raises invalid. An infinite term otherwise passes through exactly, with no flag.
- R9: A finite result too large to represent raises overflow and inexact. It returns infinity in 2'b00, the largest finite value in 2'b11, and in the directed modes infinity or the largest finite value according to the direction.
- R10: An exact zero sum of opposite-signed terms returns +0 in every mode except 2'b10, where it returns -0.
- R11: With `ftz`=0, subnormal results are rounded to the subnormal grid. Underflow is raised only when such a result is also inexact.
- R12: With `ftz`=1, subnormal inputs are treated as zero of the same sign. A result below the normal range becomes signed zero and raises underflow without inexact.
- R13: `flags` bit 0 is invalid, bit 1 overflow, bit 2 underflow and bit 3 inexact. Each bit is the OR over all lanes and over all operations since the last `clr_flags` pulse.
- R14: `done` is high for exactly one cycle, two rising edges after the edge that samples `start`. `result` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that captures operands and controls |
| clr_flags | input | 1 | Clears the sticky flags |
| rmode | input | 2 | Rounding-mode select |
| ftz | input | 1 | Flush subnormals to zero |
| dnan | input | 1 | Return the default NaN for every NaN result |
| idx | input | 3 | Element index within each 128-bit segment of `src_b` |
| src_a | input | VLEN | First source; the low half of each 32-bit slot is used |
| src_b | input | VLEN | Second source; BFloat16 elements |
| src_c | input | VLEN | Single-precision addends |
| result | output | VLEN | Single-precision results |
| done | output | 1 | Result-valid pulse |
| flags | output | 4 | Sticky exception flags |

## Verification
A wrong lane-to-element mapping for the index or the even half shows up as a wrong integer result in particular lanes on the first operation that uses distinct per-lane values. An error in alignment, normalisation or rounding shows up as a one-ulp or larger mismatch, or as a wrong inexact or underflow bit, in the cycle of the done pulse for tie, near-tie and subnormal operands. A wrong control state shows at the ports in the next done cycle or in the flags register. Examples are a stuck done, a lost sticky bit, or a result register that updates outside done.

// File: rtl/bfma_pkg.sv
package bfma_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic invalid;
    } fflags_t;

    localparam int SIG_W  = 24;              // single-precision significand
    localparam int WIN_W  = 52;              // alignment window
    localparam int MAG_W  = WIN_W + 1;       // window plus carry
    localparam int EXP_W  = 13;              // signed working exponent
    localparam int SH_CAP = 56;              // alignment shift saturation

    localparam logic [31:0] QNAN_DEF = 32'h7FC0_0000;

endpackage

// File: rtl/bfma_round.sv
module bfma_round
    import bfma_pkg::*;
(
    input  logic                    sign_i,
    input  logic [MAG_W-1:0]        mag_i,
    input  logic signed [EXP_W-1:0] etop_i,
    input  rmode_e                  rm_i,
    input  logic                    ftz_i,
    output logic [31:0]             res_o,
    output fflags_t                 flags_o
);
    localparam int LZ_W = $clog2(MAG_W + 1);

    logic [LZ_W-1:0]          lz;
    logic [MAG_W-1:0]         norm;
    logic signed [EXP_W-1:0]  e_n, bias_e, sh_full;
    logic                     tiny;
    logic [5:0]               sh;
    logic [2*MAG_W-1:0]       ext;
    logic [MAG_W-1:0]         den;
    logic                     g_bit, st_bit, inc, ovf, to_inf;
    logic [7:0]               expf;
    logic [31:0]              packed_sum;

    always_comb begin
        lz = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag_i[i]) lz = LZ_W'(MAG_W - 1 - i);
        end
        norm    = mag_i << lz;
        e_n     = etop_i - $signed({{(EXP_W-LZ_W){1'b0}}, lz});
        bias_e  = e_n + 13'sd127;
        tiny    = e_n < -13'sd126;
        sh_full = -13'sd126 - e_n;
        if (!tiny)                 sh = 6'd0;
        else if (sh_full > 13'sd55) sh = 6'd55;
        else                       sh = sh_full[5:0];

        ext    = {norm, {MAG_W{1'b0}}} >> sh;
        den    = ext[2*MAG_W-1:MAG_W];
        g_bit  = den[28];
        st_bit = (|den[27:0]) | (|ext[MAG_W-1:0]);
        expf   = den[MAG_W-1] ? bias_e[7:0] : 8'd0;

        unique case (rm_i)
            RM_NEAR: inc = g_bit & (st_bit | den[29]);
            RM_UP:   inc = ~sign_i & (g_bit | st_bit);
            RM_DOWN: inc = sign_i & (g_bit | st_bit);
            default: inc = 1'b0;
        endcase

        packed_sum = {1'b0, expf, den[51:29]} + {31'd0, inc};
        ovf    = !tiny && ((bias_e >= 13'sd255) || (packed_sum[30:23] == 8'hFF));
        to_inf = (rm_i == RM_NEAR) || (rm_i == RM_UP && !sign_i) ||
                 (rm_i == RM_DOWN && sign_i);

        flags_o = '0;
        if (ftz_i && tiny) begin
            res_o             = {sign_i, 31'd0};
            flags_o.underflow = 1'b1;
        end else if (ovf) begin
            res_o            = to_inf ? {sign_i, 8'hFF, 23'd0} : {sign_i, 31'h7F7F_FFFF};
            flags_o.overflow = 1'b1;
            flags_o.inexact  = 1'b1;
        end else begin
            res_o             = {sign_i, packed_sum[30:0]};
            flags_o.inexact   = g_bit | st_bit;
            flags_o.underflow = tiny & (g_bit | st_bit);
        end
    end
endmodule

// File: rtl/bfma_lane.sv
module bfma_lane
    import bfma_pkg::*;
(
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    input  logic [31:0] c_i,
    input  rmode_e      rm_i,
    input  logic        ftz_i,
    input  logic        dnan_i,
    output logic [31:0] res_o,
    output fflags_t     flags_o
);
    logic        a_zero, b_zero, c_zero, a_inf, b_inf, c_inf;
    logic        a_nan, b_nan, c_nan, a_snan, b_snan, c_snan;
    logic        sp, sc, p_zero, c_big, sub, sgn;
    logic [7:0]  ea_eff, eb_eff, ec_eff, sa, sb;
    logic [15:0] prod, prod_n;
    logic [23:0] sig_c, cn, big24, small24;
    logic [4:0]  lzp, lzc;
    logic signed [EXP_W-1:0] e_p, e_c, e_big, e_small, diff;
    logic [5:0]  dsh;
    logic [79:0] ext;
    logic [WIN_W-1:0] big_w, sml_w;
    logic [MAG_W-1:0] mag;
    logic        s_big, s_small;
    logic [31:0] pick, rnd_res;
    fflags_t     rnd_flg;

    always_comb begin
        a_nan  = (a_i[14:7] == 8'hFF) && (a_i[6:0] != 0);
        b_nan  = (b_i[14:7] == 8'hFF) && (b_i[6:0] != 0);
        c_nan  = (c_i[30:23] == 8'hFF) && (c_i[22:0] != 0);
        a_snan = a_nan && !a_i[6];
        b_snan = b_nan && !b_i[6];
        c_snan = c_nan && !c_i[22];
        a_inf  = (a_i[14:7] == 8'hFF) && (a_i[6:0] == 0);
        b_inf  = (b_i[14:7] == 8'hFF) && (b_i[6:0] == 0);
        c_inf  = (c_i[30:23] == 8'hFF) && (c_i[22:0] == 0);
        a_zero = (a_i[14:7] == 0) && (ftz_i || a_i[6:0] == 0);
        b_zero = (b_i[14:7] == 0) && (ftz_i || b_i[6:0] == 0);
        c_zero = (c_i[30:23] == 0) && (ftz_i || c_i[22:0] == 0);

        sp = a_i[15] ^ b_i[15];
        sc = c_i[31];
        ea_eff = (a_i[14:7] == 0) ? 8'd1 : a_i[14:7];
        eb_eff = (b_i[14:7] == 0) ? 8'd1 : b_i[14:7];
        ec_eff = (c_i[30:23] == 0) ? 8'd1 : c_i[30:23];
        sa     = a_zero ? 8'd0 : {a_i[14:7] != 0, a_i[6:0]};
        sb     = b_zero ? 8'd0 : {b_i[14:7] != 0, b_i[6:0]};
        sig_c  = c_zero ? 24'd0 : {c_i[30:23] != 0, c_i[22:0]};
        prod   = sa * sb;
        p_zero = a_zero | b_zero;

        // normalise both terms so the leading one sits at the top
        lzp = '0;
        for (int i = 0; i < 16; i++) if (prod[i]) lzp = 5'(15 - i);
        lzc = '0;
        for (int i = 0; i < 24; i++) if (sig_c[i]) lzc = 5'(23 - i);
        prod_n = prod << lzp;
        cn     = sig_c << lzc;
        e_p = $signed({5'd0, ea_eff}) + $signed({5'd0, eb_eff}) - 13'sd253
              - $signed({8'd0, lzp});
        e_c = $signed({5'd0, ec_eff}) - 13'sd127 - $signed({8'd0, lzc});

        c_big   = p_zero || (!c_zero && (e_c >= e_p));
        big24   = c_big ? cn : {prod_n, 8'd0};
        small24 = c_big ? {prod_n, 8'd0} : cn;
        e_big   = c_big ? e_c : e_p;
        e_small = c_big ? e_p : e_c;
        s_big   = c_big ? sc : sp;
        s_small = c_big ? sp : sc;
        diff    = e_big - e_small;
        if ((c_big ? p_zero : c_zero) || diff > 13'sd55) dsh = 6'(SH_CAP);
        else                                             dsh = diff[5:0];

        // align the smaller term, jamming lost bits into the window LSB
        ext   = {small24, 56'd0} >> dsh;
        sml_w = {ext[79:29], |ext[28:0]};
        big_w = {big24, 28'd0};
        sub   = s_big ^ s_small;
        if (!sub) begin
            mag = {1'b0, big_w} + {1'b0, sml_w};
            sgn = s_big;
        end else if (big_w >= sml_w) begin
            mag = {1'b0, big_w - sml_w};
            sgn = s_big;
        end else begin
            mag = {1'b0, sml_w - big_w};
            sgn = s_small;
        end
        if (mag == 0) sgn = sub ? (rm_i == RM_DOWN) : s_big;

        if (c_snan)      pick = c_i;
        else if (a_snan) pick = {a_i, 16'd0};
        else if (b_snan) pick = {b_i, 16'd0};
        else if (c_nan)  pick = c_i;
        else if (a_nan)  pick = {a_i, 16'd0};
        else             pick = {b_i, 16'd0};

        flags_o = '0;
        if ((a_inf && b_zero) || (b_inf && a_zero)) begin
            res_o           = QNAN_DEF;
            flags_o.invalid = 1'b1;
        end else if (a_nan || b_nan || c_nan) begin
            res_o           = dnan_i ? QNAN_DEF : (pick | 32'h0040_0000);
            flags_o.invalid = a_snan | b_snan | c_snan;
        end else if (a_inf || b_inf) begin
            if (c_inf && (sp != sc)) begin
                res_o           = QNAN_DEF;
                flags_o.invalid = 1'b1;
            end else begin
                res_o = {sp, 8'hFF, 23'd0};
            end
        end else if (c_inf) begin
            res_o = c_i;
        end else if (mag == 0) begin
            res_o = {sgn, 31'd0};
        end else begin
            res_o   = rnd_res;
            flags_o = rnd_flg;
        end
    end

    bfma_round u_round (
        .sign_i (sgn),
        .mag_i  (mag),
        .etop_i (e_big + 13'sd1),
        .rm_i   (rm_i),
        .ftz_i  (ftz_i),
        .res_o  (rnd_res),
        .flags_o(rnd_flg)
    );
endmodule

// File: rtl/bf16_idx_fma.sv
module bf16_idx_fma
    import bfma_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            clr_flags,
    input  logic [1:0]      rmode,
    input  logic            ftz,
    input  logic            dnan,
    input  logic [2:0]      idx,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic [VLEN-1:0] src_c,
    output logic [VLEN-1:0] result,
    output logic            done,
    output logic [3:0]      flags
);
    localparam int LANES     = VLEN / 32;
    localparam int SEG_LANES = 4;
    localparam int SEG_HALF  = 8;

    typedef struct packed {
        logic [VLEN-1:0] a;
        logic [VLEN-1:0] b;
        logic [VLEN-1:0] c;
        rmode_e          rm;
        logic            ftz;
        logic            dn;
        logic [2:0]      idx;
        logic            busy;
        logic            done;
        logic [VLEN-1:0] res;
        logic [3:0]      flags;
    } state_t;

    state_t          st_d, st_q;
    logic [VLEN-1:0] lane_res;
    logic [3:0]      lane_flg [LANES];
    logic [3:0]      flags_or;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        localparam int SEG_BASE = SEG_HALF * (e / SEG_LANES);
        logic [15:0] b_sel;
        fflags_t     flg;
        assign b_sel = st_q.b[16*SEG_BASE + 16*st_q.idx +: 16];
        bfma_lane u_lane (
            .a_i    (st_q.a[32*e +: 16]),
            .b_i    (b_sel),
            .c_i    (st_q.c[32*e +: 32]),
            .rm_i   (st_q.rm),
            .ftz_i  (st_q.ftz),
            .dnan_i (st_q.dn),
            .res_o  (lane_res[32*e +: 32]),
            .flags_o(flg)
        );
        assign lane_flg[e] = flg;

        // R7: every NaN leaving a lane is quiet
        a_r7_quiet_nan: assert property (@(posedge clk) disable iff (!rst_n)
            (done && result[32*e+23 +: 8] == 8'hFF && result[32*e +: 23] != 0)
                |-> result[32*e+22]);
        // R7: with default-NaN set, NaN results are the default pattern
        a_r7_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
            (done && $past(st_q.dn) && result[32*e+23 +: 8] == 8'hFF && result[32*e +: 23] != 0)
                |-> result[32*e +: 32] == QNAN_DEF);
    end

    always_comb begin
        flags_or = '0;
        for (int e = 0; e < LANES; e++) flags_or = flags_or | lane_flg[e];
    end

    always_comb begin
        st_d      = st_q;
        st_d.busy = start;
        st_d.done = 1'b0;
        if (start) begin
            st_d.a   = src_a;
            st_d.b   = src_b;
            st_d.c   = src_c;
            st_d.rm  = rmode_e'(rmode);
            st_d.ftz = ftz;
            st_d.dn  = dnan;
            st_d.idx = idx;
        end
        if (st_q.busy) begin
            st_d.res  = lane_res;
            st_d.done = 1'b1;
        end
        st_d.flags = (clr_flags ? 4'd0 : st_q.flags) | (st_q.busy ? flags_or : 4'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
    assign done   = st_q.done;
    assign flags  = st_q.flags;

    a_r14_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r14_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));
    a_r14_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    a_r13_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_flags) |-> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/tb_bf16_idx_fma.sv
`timescale 1ns/1ps
module tb_bf16_idx_fma;
    localparam int VLEN  = 256;
    localparam int LANES = VLEN / 32;
    localparam int HALVES = VLEN / 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0, clr_flags = 1'b0, ftz = 1'b0, dnan = 1'b0;
    logic [1:0]      rmode = 2'b00;
    logic [2:0]      idx = 3'd0;
    logic [VLEN-1:0] src_a = '0, src_b = '0, src_c = '0;
    logic [VLEN-1:0] result;
    logic            done;
    logic [3:0]      flags;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    bf16_idx_fma #(.VLEN(VLEN)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clr_flags(clr_flags),
        .rmode(rmode), .ftz(ftz), .dnan(dnan), .idx(idx),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .result(result), .done(done), .flags(flags)
    );

    function automatic logic [31:0] f32i(input int v);
        int m, p;
        logic s;
        if (v == 0) return 32'd0;
        s = v < 0;
        m = s ? -v : v;
        p = 0;
        for (int i = 0; i < 24; i++) if (m >= (1 << i)) p = i;
        return {s, 8'(127 + p), 23'((m << (23 - p)) & 32'h7F_FFFF)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk) clr_flags = 1'b1;
        @(negedge clk) clr_flags = 1'b0;
    endtask

    task automatic fill(input logic [15:0] a16, input logic [15:0] b16, input logic [31:0] c32);
        for (int e = 0; e < LANES; e++) begin
            src_a[32*e +: 32] = {16'hFFFF, a16};   // odd half is a NaN that must be ignored
            src_c[32*e +: 32] = c32;
        end
        for (int k = 0; k < HALVES; k++) src_b[16*k +: 16] = b16;
    endtask

    task automatic run_op(input logic [1:0] rm, input logic fz, input logic dn, input logic [2:0] ix);
        @(negedge clk);
        rmode = rm; ftz = fz; dnan = dn; idx = ix; start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
    endtask

    task automatic op_check(input string req, input logic [15:0] a16, input logic [15:0] b16,
                            input logic [31:0] c32, input logic [1:0] rm, input logic fz,
                            input logic dn, input logic [31:0] exp_res, input logic [3:0] exp_flg);
        clear_flags();
        fill(a16, b16, c32);
        run_op(rm, fz, dn, 3'd0);
        check({req, " lane0"}, result[31:0], exp_res);
        check({req, " last lane"}, result[VLEN-32 +: 32], exp_res);
        check({req, " flags"}, {28'd0, flags}, {28'd0, exp_flg});
    endtask

    task automatic t_reset();
        check("R1 result", result[31:0] | result[VLEN-32 +: 32], 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 flags", {28'd0, flags}, 32'd0);
    endtask

    // R2, R3, R4: distinct integers per lane and per segment element
    task automatic t_index();
        clear_flags();
        for (int ix = 0; ix < 8; ix++) begin
            for (int e = 0; e < LANES; e++) begin
                logic [31:0] fa;
                fa = f32i(e + 1);
                src_a[32*e +: 32] = {16'hFFFF, fa[31:16]};
                src_c[32*e +: 32] = f32i(100 * e);
            end
            for (int k = 0; k < HALVES; k++) begin
                logic [31:0] fb;
                fb = f32i((k % 8) + 1 + 10 * (k / 8));
                src_b[16*k +: 16] = fb[31:16];
            end
            run_op(2'b00, 1'b0, 1'b0, 3'(ix));
            for (int e = 0; e < LANES; e++) begin
                check($sformatf("R3 R2 R4 idx=%0d lane=%0d", ix, e), result[32*e +: 32],
                      f32i((e + 1) * (ix + 1 + 10 * (e / 4)) + 100 * e));
            end
        end
        check("R2 flags unaffected by odd halves", {28'd0, flags}, 32'd0);
    endtask

    task automatic t_round();
        op_check("R5 tie near-even",  16'h3F80, 16'h3F80, 32'h4B80_0000, 2'b00, 0, 0, 32'h4B80_0000, 4'h8);
        op_check("R5 tie up",         16'h3F80, 16'h3F80, 32'h4B80_0000, 2'b01, 0, 0, 32'h4B80_0001, 4'h8);
        op_check("R5 tie down",       16'h3F80, 16'h3F80, 32'h4B80_0000, 2'b10, 0, 0, 32'h4B80_0000, 4'h8);
        op_check("R5 above tie near", 16'h3F81, 16'h3F81, 32'h4B80_0000, 2'b00, 0, 0, 32'h4B80_0001, 4'h8);
        op_check("R5 above tie zero", 16'h3F81, 16'h3F81, 32'h4B80_0000, 2'b11, 0, 0, 32'h4B80_0000, 4'h8);
        op_check("R5 neg down",       16'hBF80, 16'h3F80, 32'hCB80_0000, 2'b10, 0, 0, 32'hCB80_0001, 4'h8);
        op_check("R5 neg up",         16'hBF80, 16'h3F80, 32'hCB80_0000, 2'b01, 0, 0, 32'hCB80_0000, 4'h8);
        op_check("R4 exact 1*2+1",    16'h3F80, 16'h4000, 32'h3F80_0000, 2'b00, 0, 0, 32'h4040_0000, 4'h0);
    endtask

    task automatic t_special();
        op_check("R6 inf*0 nan addend", 16'h7F80, 16'h0000, 32'h7FC0_0005, 2'b00, 0, 0, 32'h7FC0_0000, 4'h1);
        op_check("R7 snan addend",      16'h3F80, 16'h3F80, 32'h7F80_0001, 2'b00, 0, 0, 32'h7FC0_0001, 4'h1);
        op_check("R7 snan default",     16'h3F80, 16'h3F80, 32'h7F80_0001, 2'b00, 0, 1, 32'h7FC0_0000, 4'h1);
        op_check("R7 qnan first",       16'h7FC1, 16'h3F80, 32'h3F80_0000, 2'b00, 0, 0, 32'h7FC1_0000, 4'h0);
        op_check("R7 snan beats qnan",  16'h7F81, 16'h3F80, 32'h7FC0_0005, 2'b00, 0, 0, 32'h7FC1_0000, 4'h1);
        op_check("R8 inf minus inf",    16'h7F80, 16'h3F80, 32'hFF80_0000, 2'b00, 0, 0, 32'h7FC0_0000, 4'h1);
        op_check("R8 inf passes",       16'h7F80, 16'hBF80, 32'h3F80_0000, 2'b00, 0, 0, 32'hFF80_0000, 4'h0);
        op_check("R9 overflow near",    16'h7F00, 16'h4000, 32'h0000_0000, 2'b00, 0, 0, 32'h7F80_0000, 4'hA);
        op_check("R9 overflow zero",    16'h7F00, 16'h4000, 32'h0000_0000, 2'b11, 0, 0, 32'h7F7F_FFFF, 4'hA);
        op_check("R9 overflow down",    16'h7F00, 16'h4000, 32'h0000_0000, 2'b10, 0, 0, 32'h7F7F_FFFF, 4'hA);
        op_check("R10 zero near",       16'h3F80, 16'h3F80, 32'hBF80_0000, 2'b00, 0, 0, 32'h0000_0000, 4'h0);
        op_check("R10 zero down",       16'h3F80, 16'h3F80, 32'hBF80_0000, 2'b10, 0, 0, 32'h8000_0000, 4'h0);
    endtask

    task automatic t_subnormal();
        op_check("R11 exact tiny",      16'h0080, 16'h3F00, 32'h0000_0000, 2'b00, 0, 0, 32'h0040_0000, 4'h0);
        op_check("R11 inexact tiny",    16'h00C0, 16'h3400, 32'h0000_0000, 2'b00, 0, 0, 32'h0000_0002, 4'hC);
        op_check("R11 tiny toward 0",   16'h00C0, 16'h3400, 32'h0000_0000, 2'b11, 0, 0, 32'h0000_0001, 4'hC);
        op_check("R12 result flushed",  16'h0080, 16'h3F00, 32'h0000_0000, 2'b00, 1, 0, 32'h0000_0000, 4'h4);
        op_check("R11 sub input kept",  16'h0040, 16'h4000, 32'h3F80_0000, 2'b00, 0, 0, 32'h3F80_0000, 4'h8);
        op_check("R12 sub input flush", 16'h0040, 16'h4000, 32'h3F80_0000, 2'b00, 1, 0, 32'h3F80_0000, 4'h0);
    endtask

    task automatic t_sticky();
        clear_flags();
        fill(16'h3F80, 16'h4000, 32'h3F80_0000);
        src_c[32*3 +: 32] = 32'h7F80_0001;          // only lane 3 is invalid
        run_op(2'b00, 0, 0, 3'd0);
        check("R13 clean lane beside invalid", result[31:0], 32'h4040_0000);
        check("R13 OR across lanes", {28'd0, flags}, 32'd1);
        fill(16'h3F80, 16'h4000, 32'h3F80_0000);
        run_op(2'b00, 0, 0, 3'd0);
        check("R13 sticky after clean op", {28'd0, flags}, 32'd1);
        clear_flags();
        check("R13 cleared", {28'd0, flags}, 32'd0);
    endtask

    task automatic t_timing();
        fill(16'h3F80, 16'h4000, 32'h3F80_0000);
        @(negedge clk);
        rmode = 2'b00; ftz = 0; dnan = 0; idx = 0; start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R14 done low one edge after start", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R14 done high two edges after start", {31'd0, done}, 32'd1);
        check("R14 result at done", result[31:0], 32'h4040_0000);
        fill(16'h4000, 16'h4000, 32'h4000_0000);
        @(negedge clk);
        check("R14 done single cycle", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        check("R14 result held without start", result[31:0], 32'h4040_0000);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_round();
        t_special();
        t_subnormal();
        t_sticky();
        t_timing();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule